// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches the already-filtered level of one GPIO pin and turns a chosen condition on it into a sticky interrupt status bit. The condition can be a falling, rising or any edge, or a low or high level. A trigger-mode bit picks edge or level detection, and a two-bit active-level code picks the polarity or both edges. Software clears the status by writing one to a clear strobe.

Detection and delivery are controlled separately. The interrupt enable decides whether a detected event is stored in the status bit. The mask bit, which is high for unmasked, decides whether a stored status reaches the request line. A second sticky wake status is gated by its own wake enable, and it can also raise the request. The request line of each pin feeds a bank-level aggregator. The block also passes the output-enable and output-value controls through to the pad. It reports the input level as pin status while the pin is not driven.

Top module: `gpio_pin_irq`

## Requirements
- R1: After reset, intStatus, wakeStatus and irqReq are 0. The first clock edge after reset only takes a sample of pinLevel, so no edge event is detected at that edge.
- R2: In edge mode (levelTrig=0), an event is detected at the clock edge where pinLevel differs from its previous sample. activeSel 2'b00 detects a 1 to 0 change, 2'b01 a 0 to 1 change and 2'b10 either change. The status bit stays set until it is cleared.
- R3: When intEnable=0, no event sets intStatus. A status bit that is already set keeps its value.
- R4: In level mode (levelTrig=1), activeSel 2'b00 detects pinLevel=0 and 2'b01 detects pinLevel=1 at every clock edge where that level is present. After a clear, the status sets again while the level persists.
- R5: The activeSel code 2'b11 never produces an event in either mode. The code 2'b10 never produces an event in level mode.
- R6: statusClr=1 at a clock edge with no new event clears intStatus after that edge.
- R7: If statusClr=1 and an enabled event occur at the same clock edge, intStatus is 1 after that edge.
- R8: wakeStatus is set by an event while wakeEnable=1, whatever the value of intEnable. wakeClr=1 clears wakeStatus, and a new event in the same cycle wins over the clear, as in R7.
- R9: irqReq equals (intStatus AND intMask) OR (wakeStatus AND wakeEnable). It is a combinational function of the stored bits and the current controls.
- R10: padOe equals outEnable and padOut equals outValue. pinStatus equals pinLevel while outEnable=0 and is 0 while outEnable=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinLevel | input | 1 | Filtered pin input level |
| levelTrig | input | 1 | 1 selects level detection, 0 selects edge detection |
| activeSel | input | 2 | 00 low/falling, 01 high/rising, 10 both edges, 11 reserved |
| intEnable | input | 1 | Allows detected events to set intStatus |
| intMask | input | 1 | 1 = unmasked, lets intStatus reach irqReq |
| wakeEnable | input | 1 | Allows events to set wakeStatus and gates it onto irqReq |
| statusClr | input | 1 | Write-one strobe that clears intStatus |
| wakeClr | input | 1 | Write-one strobe that clears wakeStatus |
| outEnable | input | 1 | Drive enable for the pad |
| outValue | input | 1 | Value driven on the pad |
| intStatus | output | 1 | Sticky interrupt status |
| wakeStatus | output | 1 | Sticky wake status |
| irqReq | output | 1 | Per-pin request to the bank aggregator |
| padOe | output | 1 | Pad output enable |
| padOut | output | 1 | Pad output value |
| pinStatus | output | 1 | Input level while the pin is not an output |

## Verification
The status bits are due one clock edge after pinLevel, the controls or a clear strobe is presented. The edge that first samples a new pin level is the edge that updates the stored bits. irqReq and the pad outputs follow their inputs with no delay. The bench changes inputs only just after a falling edge and computes the expected next status from its own model of the previous sample. It reads every output 1 ns after the following rising edge, while the inputs are still held, so the combinational outputs are compared against the same controls that the model used.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ACT_W = 2;

  typedef enum logic [ACT_W-1:0] {
    ACT_LOW  = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_BOTH = 2'b10,
    ACT_RSVD = 2'b11
  } actSel_e;

  typedef struct packed {
    logic setStatus;
    logic setWake;
  } irqStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinLevel,
  input  logic       levelTrig,
  input  actSel_e    activeSel,
  input  logic       intEnable,
  input  logic       wakeEnable,
  output irqStrobe_t strb
);
  logic prevLevel;
  logic primed;
  logic risingEdge;
  logic fallingEdge;
  logic eventHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= 1'b0;
      primed    <= 1'b0;
    end else begin
      prevLevel <= pinLevel;
      primed    <= 1'b1;
    end
  end

  assign risingEdge  = primed && !prevLevel && pinLevel;
  assign fallingEdge = primed && prevLevel && !pinLevel;

  always_comb begin
    eventHit = 1'b0;
    if (levelTrig) begin
      unique case (activeSel)
        ACT_LOW:  eventHit = !pinLevel;
        ACT_HIGH: eventHit = pinLevel;
        default:  eventHit = 1'b0;
      endcase
    end else begin
      unique case (activeSel)
        ACT_LOW:  eventHit = fallingEdge;
        ACT_HIGH: eventHit = risingEdge;
        ACT_BOTH: eventHit = risingEdge || fallingEdge;
        default:  eventHit = 1'b0;
      endcase
    end
  end

  assign strb.setStatus = eventHit && intEnable;
  assign strb.setWake   = eventHit && wakeEnable;

  // R5
  rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeSel == ACT_RSVD) |-> !(strb.setStatus || strb.setWake));

  // R3
  enable_gates_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStatus |-> intEnable);

  // R2
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!levelTrig && (strb.setStatus || strb.setWake)) |-> (pinLevel != prevLevel));
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  irqStrobe_t strb,
  input  logic       statusClr,
  input  logic       wakeClr,
  input  logic       intMask,
  input  logic       wakeEnable,
  output logic       intStatus,
  output logic       wakeStatus,
  output logic       irqReq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStatus  <= 1'b0;
      wakeStatus <= 1'b0;
    end else begin
      intStatus  <= strb.setStatus || (intStatus && !statusClr);
      wakeStatus <= strb.setWake || (wakeStatus && !wakeClr);
    end
  end

  assign irqReq = (intStatus && intMask) || (wakeStatus && wakeEnable);

  // R6
  clear_works_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !strb.setStatus) |=> !intStatus);

  // R7
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setStatus && statusClr) |=> intStatus);

  // R2
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus && !statusClr) |=> intStatus);

  // R8
  wake_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeStatus) |-> $past(strb.setWake));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!intMask && !(wakeStatus && wakeEnable)) |-> !irqReq);
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinLevel,
  input  logic             levelTrig,
  input  logic [ACT_W-1:0] activeSel,
  input  logic             intEnable,
  input  logic             intMask,
  input  logic             wakeEnable,
  input  logic             statusClr,
  input  logic             wakeClr,
  input  logic             outEnable,
  input  logic             outValue,
  output logic             intStatus,
  output logic             wakeStatus,
  output logic             irqReq,
  output logic             padOe,
  output logic             padOut,
  output logic             pinStatus
);
  irqStrobe_t strb;
  actSel_e    actSel;

  assign actSel = actSel_e'(activeSel);

  gpio_irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pinLevel   (pinLevel),
    .levelTrig  (levelTrig),
    .activeSel  (actSel),
    .intEnable  (intEnable),
    .wakeEnable (wakeEnable),
    .strb       (strb)
  );

  gpio_irq_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .statusClr  (statusClr),
    .wakeClr    (wakeClr),
    .intMask    (intMask),
    .wakeEnable (wakeEnable),
    .intStatus  (intStatus),
    .wakeStatus (wakeStatus),
    .irqReq     (irqReq)
  );

  assign padOe     = outEnable;
  assign padOut    = outValue;
  assign pinStatus = pinLevel && !outEnable;
endmodule

// File: tb/gpio_pin_irq_tb.sv
module gpio_pin_irq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinLevel = 0, levelTrig = 0, intEnable = 0, intMask = 0, wakeEnable = 0;
  logic statusClr = 0, wakeClr = 0, outEnable = 0, outValue = 0;
  logic [1:0] activeSel = 2'b00;
  logic intStatus, wakeStatus, irqReq, padOe, padOut, pinStatus;

  int checks = 0;
  int failures = 0;
  logic mPrev = 0, mPrimed = 0, mStat = 0, mWake = 0;

  always #10 clk = ~clk;

  gpio_pin_irq u_dut (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .levelTrig(levelTrig),
    .activeSel(activeSel), .intEnable(intEnable), .intMask(intMask),
    .wakeEnable(wakeEnable), .statusClr(statusClr), .wakeClr(wakeClr),
    .outEnable(outEnable), .outValue(outValue), .intStatus(intStatus),
    .wakeStatus(wakeStatus), .irqReq(irqReq), .padOe(padOe), .padOut(padOut),
    .pinStatus(pinStatus)
  );

  function automatic logic evFn(logic prv, logic prm, logic pin, logic trg, logic [1:0] act);
    if (trg) return (act == 2'b00) ? !pin : (act == 2'b01) ? pin : 1'b0;
    if (!prm) return 1'b0;
    case (act)
      2'b00: return prv && !pin;
      2'b01: return !prv && pin;
      2'b10: return prv != pin;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    logic ev, nStat, nWake;
    ev = evFn(mPrev, mPrimed, pinLevel, levelTrig, activeSel);
    nStat = (ev && intEnable) || (mStat && !statusClr);
    nWake = (ev && wakeEnable) || (mWake && !wakeClr);
    @(posedge clk); #1;
    mStat = nStat; mWake = nWake; mPrev = pinLevel; mPrimed = 1'b1;
    check(tag, intStatus, mStat);
    check("R8", wakeStatus, mWake);
    check("R9", irqReq, (mStat && intMask) || (mWake && wakeEnable));
    check("R10", pinStatus, pinLevel && !outEnable);
    check("R10", padOe, outEnable);
    check("R10", padOut, outValue);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1d5;
    void'($urandom(seed));
    pinLevel = 1; activeSel = 2'b01; intEnable = 1; intMask = 1; wakeEnable = 1;
    repeat (3) @(negedge clk);
    check("R1", intStatus, 1'b0);
    check("R1", wakeStatus, 1'b0);
    check("R1", irqReq, 1'b0);
    rstN = 1;
    @(negedge clk);
    check("R1", intStatus, 1'b0);
    check("R1", wakeStatus, 1'b0);
    mPrev = 1; mPrimed = 1;
    // R2: falling then rising
    pinLevel = 0; step("R2");
    check("R2", intStatus, 1'b0);
    pinLevel = 1; step("R2");
    check("R2", intStatus, 1'b1);
    step("R2");
    check("R2", intStatus, 1'b1);
    // R6: clear without event
    statusClr = 1; wakeClr = 1; step("R6");
    check("R6", intStatus, 1'b0);
    statusClr = 0; wakeClr = 0;
    // R2 both edges
    activeSel = 2'b10; pinLevel = 0; step("R2");
    check("R2", intStatus, 1'b1);
    // R7: clear with new edge
    statusClr = 1; pinLevel = 1; step("R7");
    check("R7", intStatus, 1'b1);
    statusClr = 0;
    // R3: disabled detection; R8 wake independent
    statusClr = 1; wakeClr = 1; step("R6");
    statusClr = 0; wakeClr = 0; intEnable = 0;
    pinLevel = 0; step("R3");
    check("R3", intStatus, 1'b0);
    check("R8", wakeStatus, 1'b1);
    intEnable = 1; wakeClr = 1; wakeEnable = 0; step("R8");
    wakeClr = 0;
    // R9 masked
    intMask = 0; pinLevel = 1; step("R9");
    check("R9", irqReq, 1'b0);
    intMask = 1; #1; check("R9", irqReq, 1'b1);
    // R5 reserved codes
    statusClr = 1; step("R6"); statusClr = 0;
    activeSel = 2'b11; pinLevel = 0; step("R5");
    pinLevel = 1; step("R5");
    check("R5", intStatus, 1'b0);
    levelTrig = 1; activeSel = 2'b10; step("R5");
    check("R5", intStatus, 1'b0);
    // R4 level high re-sets after clear
    activeSel = 2'b01; step("R4");
    check("R4", intStatus, 1'b1);
    statusClr = 1; step("R4");
    check("R4", intStatus, 1'b1);
    pinLevel = 0; step("R6");
    check("R6", intStatus, 1'b0);
    statusClr = 0; activeSel = 2'b00; step("R4");
    check("R4", intStatus, 1'b1);
    // R10 pad
    outEnable = 1; outValue = 1; pinLevel = 1; step("R10");
    check("R10", pinStatus, 1'b0);
    outEnable = 0; step("R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      pinLevel   = $urandom_range(0, 1);
      levelTrig  = ($urandom_range(0, 3) == 0);
      activeSel  = 2'($urandom_range(0, 3));
      intEnable  = ($urandom_range(0, 3) != 0);
      intMask    = $urandom_range(0, 1);
      wakeEnable = $urandom_range(0, 1);
      statusClr  = ($urandom_range(0, 3) == 0);
      wakeClr    = ($urandom_range(0, 3) == 0);
      outEnable  = $urandom_range(0, 1);
      outValue   = $urandom_range(0, 1);
      step(levelTrig ? "R4" : "R2");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule